// File: doc/BRIEF.md
# Per-Warp Register Dependency Scoreboard

This block guards issue in an in-order, multi-warp SIMT core. Each warp owns a small reservation table of destination registers written by instructions that are still in flight, and a single instruction-buffer entry that holds the next decoded instruction of that warp. When decode fills an entry, the block compares the instruction's source and destination registers against the warp's live reservations. It stores one dependency bit per reservation slot and presents the entry as ready only when every bit is clear.

Issuing a ready entry empties it. If the instruction writes a register, issue also claims a free slot for that register. A writeback frees the slot that holds the written register and clears the matching bit in the warp's buffer entry, so a waiting instruction becomes ready once its last producer has written back. The scheduler sees only the per-warp ready vector. The register file and the choice among ready warps sit outside this block.

Top module: `warp_scoreboard`

## Requirements
- R1: While reset is asserted and directly after it, every bit of `ready_o` is 0 and no register of any warp is reserved.
- R2: A lookup into a vacant entry whose registers match no live reservation makes `ready_o[w]` 1 from the clock edge that captures the lookup.
- R3: A lookup whose enabled source register equals a register reserved in the same warp holds `ready_o[w]` at 0 (read-after-write).
- R4: A lookup whose enabled destination register equals a register reserved in the same warp holds `ready_o[w]` at 0 (write-after-write), so a warp never holds two reservations for one register.
- R5: An issue of a ready entry empties it (`ready_o[w]` is 0 after the edge). If the entry writes a register, that register is reserved in the lowest-numbered free slot of the warp.
- R6: A writeback for a register reserved in warp w frees its slot and clears that slot's bit in warp w's entry. An entry that waits on two reserved registers becomes ready only after both have been written back.
- R7: A writeback and a lookup in the same cycle, in the same warp and for the same register, leave no dependency bit for that register.
- R8: Each warp holds at most `NUM_SLOTS` reservations (default 6, from `NUM_REGS` = 128 registers). With all slots taken, an entry that writes a register is not ready, and an entry that writes no register is still ready.
- R9: An issue request for a warp whose entry is vacant or not ready has no effect: the entry stays, and no register is reserved.
- R10: A lookup into an occupied entry is ignored unless the same warp issues in that cycle. In that case the new entry sees the issuing instruction's destination as already reserved.
- R11: Reservations, writebacks and entries of different warps do not interact. A writeback of a register that is not reserved in the named warp changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Decoded instruction to place in a warp's entry |
| lkp_warp_i | input | WID_W | Warp of the lookup |
| lkp_src_en_i | input | NUM_SRC | Per-source operand enable |
| lkp_src_i | input | NUM_SRC x REG_W | Source register numbers |
| lkp_dst_en_i | input | 1 | Instruction writes a register |
| lkp_dst_i | input | REG_W | Destination register number |
| iss_valid_i | input | 1 | Scheduler issues a warp's entry |
| iss_warp_i | input | WID_W | Warp being issued |
| wb_valid_i | input | 1 | Result written back |
| wb_warp_i | input | WID_W | Warp of the writeback |
| wb_reg_i | input | REG_W | Register written back |
| ready_o | output | NUM_WARPS | Per-warp entry valid and free of hazards |

## Verification
A stale dependency bit or a slot that is never freed shows as a warp whose `ready_o` stays low after its producer has written back, one cycle after that writeback. A missed match shows as `ready_o` rising right after a lookup that should have blocked. A lost reservation shows up one cycle later, when a consumer looked up after the issue comes out ready. The directed scenarios therefore read `ready_o` on the cycle after every lookup, issue and writeback. Where a state cannot be seen directly, they make it visible through a follow-up lookup.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SB_WARPS = 4;
  localparam int SB_SLOTS = 6;
  localparam int SB_REGS  = 128;
  localparam int SB_SRCS  = 2;
endpackage

// File: rtl/sb_slot_table.sv
module sb_slot_table #(
  parameter int NUM_SLOTS = 6,
  parameter int REG_W     = 7,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             alloc_i,
  input  logic [REG_W-1:0]                 alloc_reg_i,
  input  logic [NUM_SLOTS-1:0]             rel_i,
  output logic [NUM_SLOTS-1:0]             vld_o,
  output logic [NUM_SLOTS-1:0][REG_W-1:0]  reg_o,
  output logic [SLOT_W-1:0]                free_idx_o,
  output logic                             full_o
);
  always_comb begin
    free_idx_o = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--)
      if (!vld_o[s]) free_idx_o = SLOT_W'(s);
  end
  assign full_o = &vld_o;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[s] <= 1'b0;
        reg_o[s] <= '0;
      end else if (alloc_i && !full_o && free_idx_o == SLOT_W'(s)) begin
        vld_o[s] <= 1'b1;
        reg_o[s] <= alloc_reg_i;
      end else if (rel_i[s]) begin
        vld_o[s] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sb_entry.sv
module sb_entry #(
  parameter int NUM_SLOTS = 6,
  parameter int REG_W     = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [NUM_SLOTS-1:0] load_dep_i,
  input  logic                 load_dst_en_i,
  input  logic [REG_W-1:0]     load_dst_i,
  input  logic                 clear_i,
  input  logic [NUM_SLOTS-1:0] rel_i,
  output logic                 vld_o,
  output logic [NUM_SLOTS-1:0] dep_o,
  output logic                 dst_en_o,
  output logic [REG_W-1:0]     dst_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o    <= 1'b0;
      dep_o    <= '0;
      dst_en_o <= 1'b0;
      dst_o    <= '0;
    end else if (load_i) begin
      vld_o    <= 1'b1;
      dep_o    <= load_dep_i;
      dst_en_o <= load_dst_en_i;
      dst_o    <= load_dst_i;
    end else if (clear_i) begin
      vld_o    <= 1'b0;
      dep_o    <= '0;
      dst_en_o <= 1'b0;
    end else begin
      dep_o    <= dep_o & ~rel_i;
    end
  end
endmodule

// File: rtl/warp_scoreboard.sv
module warp_scoreboard import sb_pkg::*; #(
  parameter int NUM_WARPS = SB_WARPS,
  parameter int NUM_SLOTS = SB_SLOTS,
  parameter int NUM_REGS  = SB_REGS,
  parameter int NUM_SRC   = SB_SRCS,
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            lkp_valid_i,
  input  logic [WID_W-1:0]                lkp_warp_i,
  input  logic [NUM_SRC-1:0]              lkp_src_en_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0]   lkp_src_i,
  input  logic                            lkp_dst_en_i,
  input  logic [REG_W-1:0]                lkp_dst_i,
  input  logic                            iss_valid_i,
  input  logic [WID_W-1:0]                iss_warp_i,
  input  logic                            wb_valid_i,
  input  logic [WID_W-1:0]                wb_warp_i,
  input  logic [REG_W-1:0]                wb_reg_i,
  output logic [NUM_WARPS-1:0]            ready_o
);
  logic [NUM_WARPS-1:0][NUM_SLOTS-1:0]            slot_vld, rel_hit, lkp_hit, ent_dep;
  logic [NUM_WARPS-1:0][NUM_SLOTS-1:0][REG_W-1:0] slot_reg;
  logic [NUM_WARPS-1:0][SLOT_W-1:0]               free_idx;
  logic [NUM_WARPS-1:0][REG_W-1:0]                ent_dst;
  logic [NUM_WARPS-1:0] slot_full, ent_vld, ent_dst_en, iss_fire, lkp_fire, alloc;

  // register number matches any enabled operand of the incoming lookup
  function automatic logic op_match(input logic [REG_W-1:0] r,
                                    input logic [NUM_SRC-1:0] sen,
                                    input logic [NUM_SRC-1:0][REG_W-1:0] src,
                                    input logic den,
                                    input logic [REG_W-1:0] dst);
    logic m;
    m = den && (dst == r);
    for (int k = 0; k < NUM_SRC; k++)
      if (sen[k] && src[k] == r) m = 1'b1;
    return m;
  endfunction

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_rel
      assign rel_hit[w][s] = wb_valid_i && (wb_warp_i == WID_W'(w)) &&
                             slot_vld[w][s] && (slot_reg[w][s] == wb_reg_i);
    end

    always_comb begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        lkp_hit[w][s] = slot_vld[w][s] && !rel_hit[w][s] &&
                        op_match(slot_reg[w][s], lkp_src_en_i, lkp_src_i,
                                 lkp_dst_en_i, lkp_dst_i);
        // slot being claimed by a same-cycle issue of this warp
        if (alloc[w] && free_idx[w] == SLOT_W'(s) &&
            op_match(ent_dst[w], lkp_src_en_i, lkp_src_i, lkp_dst_en_i, lkp_dst_i))
          lkp_hit[w][s] = 1'b1;
      end
    end

    assign ready_o[w]  = ent_vld[w] && !(|ent_dep[w]) && !(ent_dst_en[w] && slot_full[w]);
    assign iss_fire[w] = iss_valid_i && (iss_warp_i == WID_W'(w)) && ready_o[w];
    assign alloc[w]    = iss_fire[w] && ent_dst_en[w];
    assign lkp_fire[w] = lkp_valid_i && (lkp_warp_i == WID_W'(w)) &&
                         (!ent_vld[w] || iss_fire[w]);

    sb_slot_table #(.NUM_SLOTS(NUM_SLOTS), .REG_W(REG_W)) i_table (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (alloc[w]),
      .alloc_reg_i (ent_dst[w]),
      .rel_i       (rel_hit[w]),
      .vld_o       (slot_vld[w]),
      .reg_o       (slot_reg[w]),
      .free_idx_o  (free_idx[w]),
      .full_o      (slot_full[w])
    );

    sb_entry #(.NUM_SLOTS(NUM_SLOTS), .REG_W(REG_W)) i_entry (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .load_i        (lkp_fire[w]),
      .load_dep_i    (lkp_hit[w]),
      .load_dst_en_i (lkp_dst_en_i),
      .load_dst_i    (lkp_dst_i),
      .clear_i       (iss_fire[w]),
      .rel_i         (rel_hit[w]),
      .vld_o         (ent_vld[w]),
      .dep_o         (ent_dep[w]),
      .dst_en_o      (ent_dst_en[w]),
      .dst_o         (ent_dst[w])
    );
  end
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int NUM_WARPS = 4,
  parameter int NUM_SLOTS = 6,
  parameter int REG_W     = 7,
  parameter int WID_W     = 2
) (
  input logic                                       clk_i,
  input logic                                       rst_ni,
  input logic [NUM_WARPS-1:0]                       ready_o,
  input logic                                       iss_valid_i,
  input logic [WID_W-1:0]                           iss_warp_i,
  input logic                                       lkp_valid_i,
  input logic [WID_W-1:0]                           lkp_warp_i,
  input logic                                       wb_valid_i,
  input logic [WID_W-1:0]                           wb_warp_i,
  input logic [REG_W-1:0]                           wb_reg_i,
  input logic [NUM_WARPS-1:0][NUM_SLOTS-1:0]        slot_vld,
  input logic [NUM_WARPS-1:0][NUM_SLOTS-1:0][REG_W-1:0] slot_reg,
  input logic [NUM_WARPS-1:0][NUM_SLOTS-1:0]        ent_dep
);
  AST_RESET_IDLE: assert property (@(posedge clk_i) !rst_ni |-> (ready_o == '0)); // R1

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_w
    AST_ISSUE_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (iss_valid_i && iss_warp_i == WID_W'(w) && ready_o[w] &&
       !(lkp_valid_i && lkp_warp_i == WID_W'(w))) |=> !ready_o[w]); // R5

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_s
      AST_DEP_ON_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ent_dep[w][s] |-> slot_vld[w][s]); // R6

      AST_WB_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wb_valid_i && wb_warp_i == WID_W'(w) && slot_vld[w][s] &&
         slot_reg[w][s] == wb_reg_i) |=> !slot_vld[w][s]); // R6

      for (genvar t = s + 1; t < NUM_SLOTS; t++) begin : g_t
        AST_NO_DUP_RESERVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
          !(slot_vld[w][s] && slot_vld[w][t] && slot_reg[w][s] == slot_reg[w][t])); // R4
      end
    end
  end
endmodule

bind warp_scoreboard sb_checker #(
  .NUM_WARPS(NUM_WARPS), .NUM_SLOTS(NUM_SLOTS), .REG_W(REG_W), .WID_W(WID_W)
) i_sb_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ready_o     (ready_o),
  .iss_valid_i (iss_valid_i),
  .iss_warp_i  (iss_warp_i),
  .lkp_valid_i (lkp_valid_i),
  .lkp_warp_i  (lkp_warp_i),
  .wb_valid_i  (wb_valid_i),
  .wb_warp_i   (wb_warp_i),
  .wb_reg_i    (wb_reg_i),
  .slot_vld    (slot_vld),
  .slot_reg    (slot_reg),
  .ent_dep     (ent_dep)
);

// File: tb/test_warp_scoreboard.sv
`timescale 1ns/1ps
module test_warp_scoreboard;
  localparam int NW = 4, NS = 6, NR = 128, NSRC = 2, RW = 7, WW = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic lkp_valid_i = 0, lkp_dst_en_i = 0, iss_valid_i = 0, wb_valid_i = 0;
  logic [WW-1:0] lkp_warp_i = 0, iss_warp_i = 0, wb_warp_i = 0;
  logic [NSRC-1:0] lkp_src_en_i = 0;
  logic [NSRC-1:0][RW-1:0] lkp_src_i = 0;
  logic [RW-1:0] lkp_dst_i = 0, wb_reg_i = 0;
  logic [NW-1:0] ready_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  warp_scoreboard #(.NUM_WARPS(NW), .NUM_SLOTS(NS), .NUM_REGS(NR), .NUM_SRC(NSRC)) i_warp_scoreboard (
    .clk_i(clk), .rst_ni(rst_ni), .lkp_valid_i(lkp_valid_i), .lkp_warp_i(lkp_warp_i),
    .lkp_src_en_i(lkp_src_en_i), .lkp_src_i(lkp_src_i), .lkp_dst_en_i(lkp_dst_en_i),
    .lkp_dst_i(lkp_dst_i), .iss_valid_i(iss_valid_i), .iss_warp_i(iss_warp_i),
    .wb_valid_i(wb_valid_i), .wb_warp_i(wb_warp_i), .wb_reg_i(wb_reg_i), .ready_o(ready_o));

  task automatic chk_rdy(input int w, input logic exp, input string tag);
    n_run++;
    if (ready_o[w] !== exp) begin
      n_fail++;
      $display("FAIL %s: ready_o[%0d] = %b, expected %b", tag, w, ready_o[w], exp);
    end
  endtask

  task automatic idle_inputs();
    lkp_valid_i = 0; lkp_dst_en_i = 0; lkp_src_en_i = 0;
    iss_valid_i = 0; wb_valid_i = 0;
  endtask

  // set up lookup fields (not yet stepped)
  task automatic set_lkp(input int w, input logic e0, input int s0, input logic e1, input int s1,
                         input logic de, input int d);
    lkp_valid_i = 1; lkp_warp_i = WW'(w);
    lkp_src_en_i = {e1, e0}; lkp_src_i[0] = RW'(s0); lkp_src_i[1] = RW'(s1);
    lkp_dst_en_i = de; lkp_dst_i = RW'(d);
  endtask

  // one clock edge with the currently driven inputs, then idle
  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic lookup(input int w, input logic e0, input int s0, input logic e1, input int s1,
                        input logic de, input int d);
    @(negedge clk); set_lkp(w, e0, s0, e1, s1, de, d); step();
  endtask

  task automatic issue(input int w);
    @(negedge clk); iss_valid_i = 1; iss_warp_i = WW'(w); step();
  endtask

  task automatic wback(input int w, input int r);
    @(negedge clk); wb_valid_i = 1; wb_warp_i = WW'(w); wb_reg_i = RW'(r); step();
  endtask

  task automatic reserve(input int w, input int r);
    lookup(w, 0, 0, 0, 0, 1, r);
    issue(w);
  endtask

  task automatic do_reset();
    @(negedge clk); idle_inputs(); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
  endtask

  task automatic t_reset();
    @(negedge clk); rst_ni = 0;
    @(negedge clk);
    for (int w = 0; w < NW; w++) chk_rdy(w, 0, "R1 in reset");
    rst_ni = 1;
    @(negedge clk);
    for (int w = 0; w < NW; w++) chk_rdy(w, 0, "R1 after reset");
  endtask

  task automatic t_basic();
    do_reset();
    lookup(0, 1, 5, 1, 6, 1, 7);   chk_rdy(0, 1, "R2 clean lookup");
    issue(0);                      chk_rdy(0, 0, "R5 issue empties");
    lookup(0, 0, 0, 1, 7, 0, 0);   chk_rdy(0, 0, "R3 RAW on src1");
    wback(0, 7);                   chk_rdy(0, 1, "R6 writeback clears");
  endtask

  task automatic t_waw();
    do_reset();
    reserve(1, 10);
    lookup(1, 0, 0, 0, 0, 1, 10);  chk_rdy(1, 0, "R4 WAW");
    wback(1, 10);                  chk_rdy(1, 1, "R4 WAW resolved");
  endtask

  task automatic t_two_deps();
    do_reset();
    reserve(2, 1); reserve(2, 2);
    lookup(2, 1, 1, 1, 2, 0, 0);   chk_rdy(2, 0, "R6 two deps blocked");
    wback(2, 1);                   chk_rdy(2, 0, "R6 one dep left");
    wback(2, 2);                   chk_rdy(2, 1, "R6 both cleared");
  endtask

  task automatic t_same_cycle();
    do_reset();
    reserve(0, 20);
    @(negedge clk);
    set_lkp(0, 1, 20, 0, 0, 0, 0);
    wb_valid_i = 1; wb_warp_i = 0; wb_reg_i = 20;
    step();                        chk_rdy(0, 1, "R7 wb and lookup same cycle");
  endtask

  task automatic t_full();
    do_reset();
    for (int r = 30; r < 30 + NS; r++) reserve(3, r);
    lookup(3, 1, 50, 0, 0, 0, 0);  chk_rdy(3, 1, "R8 no-dst entry ready when full");
    issue(3);
    lookup(3, 0, 0, 0, 0, 1, 40);  chk_rdy(3, 0, "R8 writer blocked when full");
    wback(3, 32);                  chk_rdy(3, 1, "R8 writer ready after free");
    issue(3);
    lookup(3, 1, 40, 0, 0, 0, 0);  chk_rdy(3, 0, "R8 freed slot took new reg");
  endtask

  task automatic t_ignored_issue();
    do_reset();
    issue(1);                      chk_rdy(1, 0, "R9 issue on vacant");
    reserve(1, 3);
    lookup(1, 0, 0, 0, 0, 1, 3);
    issue(1);                      // not ready: must be ignored
    wback(1, 3);                   chk_rdy(1, 1, "R9 entry survived blocked issue");
    lookup(0, 0, 0, 0, 0, 0, 0);   // unrelated warp
    issue(1);
    lookup(1, 1, 3, 0, 0, 0, 0);   chk_rdy(1, 0, "R9 reserved only on real issue");
  endtask

  task automatic t_occupied();
    do_reset();
    lookup(2, 1, 8, 0, 0, 0, 0);   chk_rdy(2, 1, "R10 first lookup");
    lookup(2, 0, 0, 0, 0, 1, 9);   // occupied: ignored
    issue(2);                      // issues src-only entry, reserves nothing
    lookup(2, 1, 9, 0, 0, 0, 0);   chk_rdy(2, 1, "R10 ignored lookup left no reservation");
    issue(2);
    lookup(2, 0, 0, 0, 0, 1, 11);  chk_rdy(2, 1, "R10 writer entry");
    @(negedge clk);
    iss_valid_i = 1; iss_warp_i = 2;
    set_lkp(2, 1, 11, 0, 0, 0, 0);
    step();                        chk_rdy(2, 0, "R10 issue+lookup bypass");
    wback(2, 11);                  chk_rdy(2, 1, "R10 bypass bit cleared");
  endtask

  task automatic t_warps();
    do_reset();
    reserve(0, 60);
    lookup(1, 1, 60, 0, 0, 1, 60); chk_rdy(1, 1, "R11 other warp unaffected");
    wback(1, 60);
    wback(0, 99);
    lookup(0, 1, 60, 0, 0, 0, 0);  chk_rdy(0, 0, "R11 foreign/unreserved wb no effect");
    wback(0, 60);                  chk_rdy(0, 1, "R11 own wb releases");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_waw();
    t_two_deps();
    t_same_cycle();
    t_full();
    t_ignored_issue();
    t_occupied();
    t_warps();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule